// File: doc/BRIEF.md
# Word-to-Bit Serializer with Loopback Steering

This block turns 16-bit parallel words into a serial bit stream on a bit-rate clock. A word-rate timer divides the bit clock by the word width. The timer drives a word clock out to upstream logic, so that logic runs locked in frequency and phase to the serializer. The same timer gives the load strobe that moves each word into a shift register. The most significant bit of each word goes out first. The next word follows the last bit of the previous one with no idle bit between them.

Two loopback paths sit at the output. In line loopback, an external serial data and clock pair replace the serializer's own data and clock on the main output. The change takes effect only at a word boundary. In diagnostic loopback, selected by an active-low enable, the serializer's stream is copied to a second data and clock pair, with the data retimed on the falling bit-clock edge. When that enable is inactive, the copy is held low. Bit-clock lock is an input flag. Until the flag is high, the block holds its timing at rest.

The timer is a two-state machine. HOLD is entered on reset. While in HOLD the counter, shift register and word clock are kept at zero. The transition HOLD→RUN ("lock gained") is taken on a rising clock edge that sees the lock flag high. In RUN the counter counts bit clocks and loads a word every 16th cycle. The transition RUN→HOLD ("lock lost") is taken on any edge that sees the lock flag low. That edge also flushes the counter and shift register.

Top module: `ser_lb_top`

## Requirements
- R1: Each loaded word is sent with bit 15 first and bit 0 last, one bit per bit-clock cycle. `ser_dat` shows bit 15 in the cycle right after the load edge.
- R2: Words are sent back to back. The cycle after bit 0 of one word carries bit 15 of the next word. No bit is skipped or repeated.
- R3: The first load edge is the 16th rising edge after the edge that enters RUN. Later loads follow every 16 edges. `word_in` is sampled on the load edge.
- R4: `word_clk` has a period of 16 bit clocks. It is low for the first 8 cycles of each word and high for the last 8. It falls on the load edge.
- R5: While `rst_n` is low, or on any edge where `lock_ok` is low, these are held at 0: the counter, the shifter output and `word_clk`. `word_clk` does not toggle. Timing restarts from R3 once lock returns.
- R6: With line loopback selected, `ser_dat` carries `line_lb_dat` and `ser_clk` carries `line_lb_clk`. Otherwise they carry the serializer bit and `clk_bit`.
- R7: `line_lb_en` is sampled only on load edges and on HOLD/flush edges. A change in mid-word has no effect on `ser_dat` until the next word boundary. The reset value is 0, meaning the serializer is selected.
- R8: `diag_lb_n` is active low. When it is high, `diag_dat` and `diag_clk` stay 0. `ser_dat` is not affected by `diag_lb_n` in either state.
- R9: When `diag_lb_n` is low, `diag_dat` copies the serializer bit (never the line-loopback data) and updates on the falling `clk_bit` edge. `diag_clk` is `clk_bit` gated by the enable, which is sampled on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_ok | input | 1 | Bit clock is locked and usable |
| word_in | input | 16 | Parallel word, sampled on load edge |
| line_lb_en | input | 1 | Select line loopback on main output |
| line_lb_dat | input | 1 | Line loopback serial data |
| line_lb_clk | input | 1 | Line loopback serial clock |
| diag_lb_n | input | 1 | Diagnostic loopback enable, active low |
| ser_dat | output | 1 | Main serial data |
| ser_clk | output | 1 | Main forwarded serial clock |
| word_clk | output | 1 | Word-rate clock for upstream logic |
| diag_dat | output | 1 | Diagnostic loopback data |
| diag_clk | output | 1 | Diagnostic loopback clock |

## Verification
Some properties are checked on every cycle by the assertions:
- the counter steps by one and wraps to zero on each load,
- a flush clears the counter and `word_clk`,
- the bit after a load is the word's top bit, and each later bit is the next lower one,
- the loopback select holds between word boundaries,
- the diagnostic data stays low while its enable is off.

Other behaviour only shows in the bench's scenarios, where a queue-based model is compared on every clock:
- the exact position of the first load after lock is gained,
- bit order across random words sent back to back,
- the restart after lock is lost and after reset,
- the effect of toggling line loopback in mid-word,
- the falling-edge retiming of the diagnostic copy.

// File: rtl/ser_lb_pkg.sv
`timescale 1ns/1ps
package ser_lb_pkg;
    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } ser_state_e;

    localparam int unsigned DEF_WORD_W = 16;
endpackage

// File: rtl/ser_word_timer.sv
`timescale 1ns/1ps
module ser_word_timer
    import ser_lb_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic clk_bit,
    input  logic rst_n,
    input  logic lock_i,
    output logic load_o,
    output logic flush_o,
    output logic wclk_o
);
    localparam int unsigned CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam int unsigned LAST  = WORD_W - 1;
    localparam int unsigned HALF  = WORD_W / 2;

    ser_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wclk_q;

    // state register
    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // transitions: lock gained / lock lost
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (lock_i)  state_d = ST_RUN;
            ST_RUN:  if (!lock_i) state_d = ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    // outputs and counter next value
    always_comb begin
        load_o  = 1'b0;
        flush_o = 1'b1;
        cnt_d   = '0;
        unique case (state_q)
            ST_HOLD: begin
                flush_o = 1'b1;
            end
            ST_RUN: begin
                if (lock_i) begin
                    flush_o = 1'b0;
                    if (cnt_q == CNT_W'(LAST)) begin
                        load_o = 1'b1;
                        cnt_d  = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: flush_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            wclk_q <= (cnt_d >= CNT_W'(HALF));
        end
    end

    assign wclk_o = wclk_q;

    a_r3_wrap_on_load: assert property (@(posedge clk_bit) disable iff (!rst_n)
        load_o |=> (cnt_q == '0));
    a_r3_step_by_one: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (!flush_o && !load_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
    a_r5_flush_clears: assert property (@(posedge clk_bit) disable iff (!rst_n)
        flush_o |=> (cnt_q == '0 && !wclk_o));
    a_r4_wclk_falls_at_load: assert property (@(posedge clk_bit) disable iff (!rst_n)
        load_o |=> !wclk_o);
endmodule

// File: rtl/ser_shifter.sv
`timescale 1ns/1ps
module ser_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              flush_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              bit_o
);
    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n)       sh_q <= '0;
        else if (flush_i) sh_q <= '0;
        else if (load_i)  sh_q <= word_i;
        else              sh_q <= {sh_q[WORD_W-2:0], 1'b0};
    end

    assign bit_o = sh_q[WORD_W-1];

    a_r1_msb_after_load: assert property (@(posedge clk_bit) disable iff (!rst_n)
        load_i |=> (bit_o == $past(word_i[WORD_W-1])));
    a_r2_next_lower_bit: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (!load_i && !flush_i) |=> (bit_o == $past(sh_q[WORD_W-2])));
endmodule

// File: rtl/ser_out_steer.sv
`timescale 1ns/1ps
module ser_out_steer (
    input  logic clk_bit,
    input  logic rst_n,
    input  logic load_i,
    input  logic flush_i,
    input  logic bit_i,
    input  logic line_en_i,
    input  logic line_dat_i,
    input  logic line_clk_i,
    input  logic diag_n_i,
    output logic ser_dat_o,
    output logic ser_clk_o,
    output logic diag_dat_o,
    output logic diag_clk_o
);
    logic sel_q;
    logic dg_on_q;
    logic dg_dat_q;

    // line loopback select, taken only at word boundaries or while flushed
    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n)                  sel_q <= 1'b0;
        else if (load_i || flush_i)  sel_q <= line_en_i;
    end

    assign ser_dat_o = sel_q ? line_dat_i : bit_i;
    assign ser_clk_o = sel_q ? line_clk_i : clk_bit;

    // diagnostic copy, retimed on the falling edge
    always_ff @(negedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            dg_on_q  <= 1'b0;
            dg_dat_q <= 1'b0;
        end else begin
            dg_on_q  <= !diag_n_i;
            dg_dat_q <= !diag_n_i && bit_i;
        end
    end

    assign diag_dat_o = dg_dat_q;
    assign diag_clk_o = clk_bit & dg_on_q;

    a_r7_select_holds_mid_word: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (!load_i && !flush_i) |=> $stable(sel_q));
    a_r8_diag_idle_low: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !dg_on_q |-> !dg_dat_q);
endmodule

// File: rtl/ser_lb_top.sv
`timescale 1ns/1ps
module ser_lb_top
    import ser_lb_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic              lock_ok,
    input  logic [WORD_W-1:0] word_in,
    input  logic              line_lb_en,
    input  logic              line_lb_dat,
    input  logic              line_lb_clk,
    input  logic              diag_lb_n,
    output logic              ser_dat,
    output logic              ser_clk,
    output logic              word_clk,
    output logic              diag_dat,
    output logic              diag_clk
);
    logic load_w, flush_w, bit_w;

    ser_word_timer #(.WORD_W(WORD_W)) u_timer (
        .clk_bit (clk_bit),
        .rst_n   (rst_n),
        .lock_i  (lock_ok),
        .load_o  (load_w),
        .flush_o (flush_w),
        .wclk_o  (word_clk)
    );

    ser_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk_bit (clk_bit),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .flush_i (flush_w),
        .word_i  (word_in),
        .bit_o   (bit_w)
    );

    ser_out_steer u_steer (
        .clk_bit    (clk_bit),
        .rst_n      (rst_n),
        .load_i     (load_w),
        .flush_i    (flush_w),
        .bit_i      (bit_w),
        .line_en_i  (line_lb_en),
        .line_dat_i (line_lb_dat),
        .line_clk_i (line_lb_clk),
        .diag_n_i   (diag_lb_n),
        .ser_dat_o  (ser_dat),
        .ser_clk_o  (ser_clk),
        .diag_dat_o (diag_dat),
        .diag_clk_o (diag_clk)
    );
endmodule

// File: tb/ser_lb_top_test.sv
`timescale 1ns/1ps
module ser_lb_top_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lock_ok = 1'b1;
    logic [W-1:0] word_in = '0;
    logic         line_lb_en = 1'b0;
    logic         line_lb_dat = 1'b0;
    logic         line_lb_clk = 1'b0;
    logic         diag_lb_n = 1'b1;
    logic         ser_dat, ser_clk, word_clk, diag_dat, diag_clk;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ser_lb_top #(.WORD_W(W)) uut (
        .clk_bit(clk), .rst_n(rst_n), .lock_ok(lock_ok), .word_in(word_in),
        .line_lb_en(line_lb_en), .line_lb_dat(line_lb_dat), .line_lb_clk(line_lb_clk),
        .diag_lb_n(diag_lb_n), .ser_dat(ser_dat), .ser_clk(ser_clk),
        .word_clk(word_clk), .diag_dat(diag_dat), .diag_clk(diag_clk)
    );

    // behavioural reference
    logic q[$];
    int   m_cnt = 0;
    bit   m_run = 0;
    bit   m_sel = 0;
    bit   m_flushed = 1;
    bit   m_dg_on = 0;
    bit   m_dg_dat = 0;

    function automatic bit m_bit();
        return (q.size() > 0) ? q[0] : 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; q.delete(); m_sel = 0; m_flushed = 1;
        end else begin
            if (!m_run || !lock_ok) begin
                m_cnt = 0; q.delete(); m_sel = line_lb_en; m_flushed = 1;
            end else if (m_cnt == W-1) begin
                q.delete();
                for (int i = W-1; i >= 0; i--) q.push_back(word_in[i]);
                m_sel = line_lb_en; m_cnt = 0; m_flushed = 0;
            end else begin
                if (q.size() > 0) void'(q.pop_front());
                m_cnt++; m_flushed = 0;
            end
            m_run = lock_ok;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            m_dg_on = 0; m_dg_dat = 0;
        end else begin
            m_dg_on  = !diag_lb_n;
            m_dg_dat = !diag_lb_n && m_bit();
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // compare on every clock, away from the edges
    always @(posedge clk) begin
        #5;
        if (!rst_n || m_flushed) begin
            chk("R5 word_clk held low", word_clk, 1'b0);
            if (!m_sel) chk("R5 ser_dat held low", ser_dat, 1'b0);
        end
        chk("R4 word_clk phase", word_clk, (m_cnt >= W/2));
        if (m_sel) chk("R6 R7 ser_dat from line loopback", ser_dat, line_lb_dat);
        else       chk("R1 R2 R3 R7 ser_dat serializer bit", ser_dat, m_bit());
        chk("R6 ser_clk source", ser_clk, m_sel ? line_lb_clk : 1'b1);
        chk("R8 R9 diag_dat", diag_dat, rst_n ? m_dg_dat : 1'b0);
        chk("R8 R9 diag_clk", diag_clk, rst_n ? m_dg_on : 1'b0);
    end

    // drive all inputs mid low phase
    task automatic drive(input int n, input bit rnd_line);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #15;
            word_in     = W'($urandom);
            line_lb_dat = 1'($urandom);
            line_lb_clk = 1'($urandom);
            if (rnd_line && ($urandom % 7 == 0)) line_lb_en = ~line_lb_en;
        end
    endtask

    initial begin
        // R5: reset state and no toggling of word_clk during reset
        drive(6, 0);
        @(posedge clk); #15; rst_n = 1'b1;
        // R1 R2 R3 R4: plain serialization, diagnostic path off (R8)
        drive(80, 0);
        // R9: diagnostic copy on
        @(posedge clk); #15; diag_lb_n = 1'b0;
        drive(60, 0);
        // R6 R7: line loopback toggled at arbitrary points inside words
        @(posedge clk); #15; line_lb_en = 1'b1;
        drive(7, 0);
        @(posedge clk); #15; line_lb_en = 1'b0;
        drive(40, 0);
        drive(120, 1);
        @(posedge clk); #15; line_lb_en = 1'b0;
        drive(20, 0);
        // R5 R3: lock lost for a few cycles, then regained
        @(posedge clk); #15; lock_ok = 1'b0;
        drive(5, 0);
        @(posedge clk); #15; lock_ok = 1'b1;
        drive(50, 0);
        // R8: diagnostic off, main stream unaffected
        @(posedge clk); #15; diag_lb_n = 1'b1;
        drive(40, 0);
        // R5: reset in mid-word
        drive(9, 0);
        @(posedge clk); #15; rst_n = 1'b0;
        drive(4, 0);
        @(posedge clk); #15; rst_n = 1'b1; diag_lb_n = 1'b0;
        drive(200, 1);
        @(posedge clk); #15;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule